// File: doc/BRIEF.md
# Even/Odd Black-Level Corrector

This block sits behind the digitizer of a linear image sensor readout. Each incoming sample carries the element index it occupies in the line, as counted by the timing generator, plus a dummy tag. The shielded elements at the head of the line are averaged into two black levels, one for even indices and one for odd indices, because the two halves of the array leave through separate readout channels with their own offsets.

Each effective pixel that follows then has its own parity's black level subtracted. The result is clamped at zero and sent out one cycle later, tagged with its index. While the effective pixels stream through, the block keeps running minimum, maximum and sum of the corrected values for each parity. When the last effective index has been seen, it publishes these figures as one consistent set and pulses a line-done flag. Downstream logic can use them to judge the nonuniformity of the response.

Samples must arrive in increasing index order. Any number of idle (valid low) cycles may sit between them. The black region always ends before the effective region starts, so the black levels computed from a line are applied to that same line.

Top module: `black_level_corrector`

## Requirements
- R1: The even black level is the sum of the non-dummy samples at indices 24, 26, ..., 52 divided by 15, rounded to nearest with halves rounded up. A dummy-tagged black sample adds zero to the sum, and the divisor stays 15.
- R2: The odd black level is formed the same way from indices 25, 27, ..., 53.
- R3: A valid, non-dummy sample whose index lies in 56..3055 produces one output on the next cycle: out_valid is 1, out_idx equals the index, and out_data equals the sample minus the black level of the index's parity (bit 0 of the index: 0 is even, 1 is odd).
- R4: When a sample is at or below its parity's black level, out_data is 0, never a wrapped value.
- R5: A sample outside 56..3055, or a cycle with in_valid low, produces no output (out_valid stays 0 in the following cycle).
- R6: A dummy-tagged sample produces no output and is excluded from both the black sums and the statistics.
- R7: For each parity, the published minimum and maximum are those of the corrected values of that parity's non-dummy effective pixels in the line. If a parity saw none, it reports minimum 4095 and maximum 0.
- R8: For each parity, the published mean is the sum of its corrected effective values divided by 1500, rounded to nearest with halves rounded up.
- R9: The six statistics outputs and line_done change together, exactly two cycles after the sample at index 3055 is accepted (with in_valid high, whether dummy or not). line_done lasts one cycle, and the statistics hold until the next such event.
- R10: Black levels are latched one cycle after the sample at index 53 and are held for the rest of the line, so each line is corrected with its own black levels.
- R11: After reset, out_valid, line_done and all statistics outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_dummy | input | 1 | Sample is tagged dummy and is to be discarded |
| in_idx | input | IDX_W (12) | Element index of the sample within the line |
| in_data | input | DATA_W (12) | Digitized sample |
| out_valid | output | 1 | Corrected pixel present |
| out_idx | output | IDX_W (12) | Index of the corrected pixel |
| out_data | output | DATA_W (12) | Corrected pixel, clamped at zero |
| line_done | output | 1 | One-cycle pulse when the statistics are updated |
| even_min | output | DATA_W (12) | Lowest corrected even pixel of the last line |
| even_max | output | DATA_W (12) | Highest corrected even pixel of the last line |
| even_mean | output | DATA_W (12) | Rounded mean of corrected even pixels |
| odd_min | output | DATA_W (12) | Lowest corrected odd pixel of the last line |
| odd_max | output | DATA_W (12) | Highest corrected odd pixel of the last line |
| odd_mean | output | DATA_W (12) | Rounded mean of corrected odd pixels |

## Verification
Two things happen in the same cycle when the first effective pixel of a line (index 56) is accepted. The per-parity accumulators restart, and that pixel is folded into them. If the restart were lost, or the fold dropped, the previous line's extremes would leak into the new statistics. The bench sends two lines back to back with no idle cycle between them: the first line holds an extreme at that index, and the second line holds the opposite extreme there. It then compares the second line's published minimum, maximum and mean against values computed from that line alone. Idle cycles that carry the last effective index on the data lines check that an invalid cycle can neither publish statistics nor emit a pixel.

// File: rtl/blc_pkg.sv
package blc_pkg;
  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } parity_e;
endpackage

// File: rtl/blc_recip_div.sv
// Constant divide by reciprocal multiply, round to nearest (halves up).
// The reciprocal is rounded up and the shift sized so the error stays below 1/DIV.
module blc_recip_div #(
  parameter int SUM_W = 16,
  parameter int DIV   = 15,
  parameter int Q_W   = 12
) (
  input  logic [SUM_W-1:0] sum,
  output logic [Q_W-1:0]   q
);
  localparam int SH  = SUM_W + $clog2(DIV) + 1;
  localparam int P_W = SUM_W + SH + 1;
  localparam logic [SH:0] RECIP =
    (SH+1)'(((64'd1 << SH) + 64'(DIV) - 64'd1) / 64'(DIV));

  logic [P_W-1:0] prod;
  always_comb begin
    prod = P_W'(sum) * P_W'(RECIP) + (P_W'(1) << (SH - 1));
    q    = Q_W'(prod >> SH);
  end
endmodule

// File: rtl/blc_black_avg.sv
module blc_black_avg #(
  parameter int DATA_W    = 12,
  parameter int IDX_W     = 12,
  parameter int BLK_FIRST = 24,
  parameter int BLK_NUM   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic              s_dummy,
  input  logic [IDX_W-1:0]  s_idx,
  input  logic [DATA_W-1:0] s_data,
  output logic [DATA_W-1:0] mean_even,
  output logic [DATA_W-1:0] mean_odd
);
  localparam int BLK_LAST = BLK_FIRST + 2 * BLK_NUM - 1;
  localparam int BSUM_W   = DATA_W + $clog2(BLK_NUM + 1);

  logic              in_blk;
  logic              done_q;
  logic [DATA_W-1:0] mean_arr [2];

  assign in_blk = s_valid && (s_idx >= IDX_W'(BLK_FIRST)) && (s_idx <= IDX_W'(BLK_LAST));

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= s_valid && (s_idx == IDX_W'(BLK_LAST));
  end

  for (genvar p = 0; p < 2; p++) begin : g_par
    logic [BSUM_W-1:0] sum_q;
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] mean_r;
    logic              hit;
    logic              clr;

    assign hit = in_blk && (s_idx[0] == 1'(p));
    assign clr = (s_idx == IDX_W'(BLK_FIRST + p));

    always_ff @(posedge clk) begin
      if (rst)      sum_q <= '0;
      else if (hit) sum_q <= (clr ? '0 : sum_q) + (s_dummy ? '0 : BSUM_W'(s_data));
    end

    blc_recip_div #(.SUM_W(BSUM_W), .DIV(BLK_NUM), .Q_W(DATA_W)) u_div (
      .sum (sum_q),
      .q   (q)
    );

    always_ff @(posedge clk) begin
      if (rst)         mean_r <= '0;
      else if (done_q) mean_r <= q;
    end

    assign mean_arr[p] = mean_r;
  end

  assign mean_even = mean_arr[0];
  assign mean_odd  = mean_arr[1];

  AST_MEAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(s_valid && (s_idx == IDX_W'(BLK_LAST))) |=> $stable(mean_even) && $stable(mean_odd)); // R10
endmodule

// File: rtl/blc_stat_track.sv
module blc_stat_track #(
  parameter int DATA_W  = 12,
  parameter int EFF_NUM = 3000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_take,
  input  logic              pix_par,
  input  logic              pix_first,
  input  logic              pix_last,
  input  logic [DATA_W-1:0] pix_val,
  output logic              line_done,
  output logic [DATA_W-1:0] even_min,
  output logic [DATA_W-1:0] even_max,
  output logic [DATA_W-1:0] even_mean,
  output logic [DATA_W-1:0] odd_min,
  output logic [DATA_W-1:0] odd_max,
  output logic [DATA_W-1:0] odd_mean
);
  localparam int HALF   = EFF_NUM / 2;
  localparam int SSUM_W = DATA_W + $clog2(HALF + 1);

  logic              last_q;
  logic [DATA_W-1:0] min_arr  [2];
  logic [DATA_W-1:0] max_arr  [2];
  logic [DATA_W-1:0] mean_arr [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q    <= 1'b0;
      line_done <= 1'b0;
    end else begin
      last_q    <= pix_last;
      line_done <= last_q;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_par
    logic [DATA_W-1:0] acc_min, acc_max, base_min, base_max;
    logic [DATA_W-1:0] min_r, max_r, mean_r, q;
    logic [SSUM_W-1:0] acc_sum, base_sum;
    logic              hit;

    assign hit = pix_take && (pix_par == 1'(p));

    always_comb begin
      base_min = pix_first ? '1 : acc_min;
      base_max = pix_first ? '0 : acc_max;
      base_sum = pix_first ? '0 : acc_sum;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_min <= '1;
        acc_max <= '0;
        acc_sum <= '0;
      end else if (pix_first || hit) begin
        acc_min <= (hit && (pix_val < base_min)) ? pix_val : base_min;
        acc_max <= (hit && (pix_val > base_max)) ? pix_val : base_max;
        acc_sum <= base_sum + (hit ? SSUM_W'(pix_val) : '0);
      end
    end

    blc_recip_div #(.SUM_W(SSUM_W), .DIV(HALF), .Q_W(DATA_W)) u_div (
      .sum (acc_sum),
      .q   (q)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        min_r  <= '0;
        max_r  <= '0;
        mean_r <= '0;
      end else if (last_q) begin
        min_r  <= acc_min;
        max_r  <= acc_max;
        mean_r <= q;
      end
    end

    assign min_arr[p]  = min_r;
    assign max_arr[p]  = max_r;
    assign mean_arr[p] = mean_r;
  end

  assign even_min  = min_arr[0];
  assign even_max  = max_arr[0];
  assign even_mean = mean_arr[0];
  assign odd_min   = min_arr[1];
  assign odd_max   = max_arr[1];
  assign odd_mean  = mean_arr[1];

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    line_done |=> !line_done); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(line_done) |-> $past(pix_last, 2)); // R9
endmodule

// File: rtl/black_level_corrector.sv
module black_level_corrector
  import blc_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int IDX_W     = 12,
  parameter int BLK_FIRST = 24,
  parameter int BLK_NUM   = 15,
  parameter int EFF_FIRST = 56,
  parameter int EFF_NUM   = 3000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_dummy,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_idx,
  output logic [DATA_W-1:0] out_data,
  output logic              line_done,
  output logic [DATA_W-1:0] even_min,
  output logic [DATA_W-1:0] even_max,
  output logic [DATA_W-1:0] even_mean,
  output logic [DATA_W-1:0] odd_min,
  output logic [DATA_W-1:0] odd_max,
  output logic [DATA_W-1:0] odd_mean
);
  localparam int EFF_LAST = EFF_FIRST + EFF_NUM - 1;

  logic [DATA_W-1:0] mean_even, mean_odd, blk_sel, corr;
  logic              is_eff, take, first_hit, last_hit;

  always_comb begin
    is_eff    = (in_idx >= IDX_W'(EFF_FIRST)) && (in_idx <= IDX_W'(EFF_LAST));
    take      = in_valid && !in_dummy && is_eff;
    first_hit = in_valid && (in_idx == IDX_W'(EFF_FIRST));
    last_hit  = in_valid && (in_idx == IDX_W'(EFF_LAST));
    blk_sel   = (parity_e'(in_idx[0]) == PAR_ODD) ? mean_odd : mean_even;
    corr      = (in_data > blk_sel) ? (in_data - blk_sel) : '0;
  end

  blc_black_avg #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .BLK_FIRST(BLK_FIRST), .BLK_NUM(BLK_NUM)
  ) u_black (
    .clk       (clk),
    .rst       (rst),
    .s_valid   (in_valid),
    .s_dummy   (in_dummy),
    .s_idx     (in_idx),
    .s_data    (in_data),
    .mean_even (mean_even),
    .mean_odd  (mean_odd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_idx  <= in_idx;
        out_data <= corr;
      end
    end
  end

  blc_stat_track #(.DATA_W(DATA_W), .EFF_NUM(EFF_NUM)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .pix_take  (take),
    .pix_par   (in_idx[0]),
    .pix_first (first_hit),
    .pix_last  (last_hit),
    .pix_val   (corr),
    .line_done (line_done),
    .even_min  (even_min),
    .even_max  (even_max),
    .even_mean (even_mean),
    .odd_min   (odd_min),
    .odd_max   (odd_max),
    .odd_mean  (odd_mean)
  );

  AST_CLAMP_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data <= $past(in_data)); // R4
  AST_NO_DUMMY_OUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && !in_dummy)); // R6
  AST_OUT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_idx >= IDX_W'(EFF_FIRST)) && (out_idx <= IDX_W'(EFF_LAST))); // R5
  AST_OUT_IDX_ECHO: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_idx == $past(in_idx)); // R3
endmodule

// File: tb/black_level_corrector_tb.sv
module black_level_corrector_tb;
  localparam int DATA_W = 12, IDX_W = 12;
  localparam int LINE_LEN = 3066, EFF_FIRST = 56, EFF_LAST = 3055;
  localparam int BLK_FIRST = 24, BLK_LAST = 53, HALF = 1500;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_dummy = 1'b0;
  logic [IDX_W-1:0] in_idx = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic out_valid, line_done;
  logic [IDX_W-1:0] out_idx;
  logic [DATA_W-1:0] out_data, even_min, even_max, even_mean, odd_min, odd_max, odd_mean;

  always #4 clk = ~clk;

  black_level_corrector u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dummy(in_dummy), .in_idx(in_idx),
    .in_data(in_data), .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data),
    .line_done(line_done), .even_min(even_min), .even_max(even_max), .even_mean(even_mean),
    .odd_min(odd_min), .odd_max(odd_max), .odd_mean(odd_mean)
  );

  int n_checks = 0, n_errs = 0;
  int ln_data [LINE_LEN];
  bit ln_dum  [LINE_LEN];
  int exp_be, exp_bo;
  int e_min[2], e_max[2], e_mean[2];
  bit pv_valid = 0;
  int pv_data = 0, pv_idx = 0;
  string pv_req = "R5";
  bit ld1 = 0, ld2 = 0;
  int seed = 7;

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 4095;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit d, int idx, int data);
    int blk, x;
    bit eff;
    @(negedge clk);
    check(out_valid == pv_valid, pv_req, "out_valid", out_valid, pv_valid);
    if (pv_valid) begin
      check(out_data == pv_data, pv_req, "out_data", out_data, pv_data);
      check(out_idx == pv_idx, "R3", "out_idx", out_idx, pv_idx);
    end
    check(line_done == ld2, "R9", "line_done", line_done, ld2);
    ld2 = ld1;
    ld1 = v && (idx == EFF_LAST);
    in_valid = v; in_dummy = d; in_idx = IDX_W'(idx); in_data = DATA_W'(data);
    eff = (idx >= EFF_FIRST) && (idx <= EFF_LAST);
    blk = idx[0] ? exp_bo : exp_be;
    x = (data > blk) ? data - blk : 0;
    pv_valid = v && !d && eff;
    pv_data = x;
    pv_idx = idx;
    if (!(v && eff))     pv_req = "R5";
    else if (d)          pv_req = "R6";
    else if (data <= blk) pv_req = "R4";
    else                 pv_req = idx[0] ? "R2,R3" : "R1,R3";
  endtask

  task automatic run_line(bit gaps);
    int s[2], sum[2], cnt[2];
    s[0] = 0; s[1] = 0;
    for (int i = BLK_FIRST; i <= BLK_LAST; i++) if (!ln_dum[i]) s[i % 2] += ln_data[i];
    exp_be = (s[0] + 7) / 15;
    exp_bo = (s[1] + 7) / 15;
    for (int p = 0; p < 2; p++) begin e_min[p] = 4095; e_max[p] = 0; sum[p] = 0; cnt[p] = 0; end
    for (int i = EFF_FIRST; i <= EFF_LAST; i++) begin
      int b, x;
      if (ln_dum[i]) continue;
      b = (i % 2) ? exp_bo : exp_be;
      x = (ln_data[i] > b) ? ln_data[i] - b : 0;
      if (x < e_min[i % 2]) e_min[i % 2] = x;
      if (x > e_max[i % 2]) e_max[i % 2] = x;
      sum[i % 2] += x;
      cnt[i % 2]++;
    end
    for (int p = 0; p < 2; p++) e_mean[p] = (sum[p] + HALF / 2) / HALF;
    for (int i = 0; i < LINE_LEN; i++) begin
      if (gaps && (i % 5 == 2)) step(0, 0, EFF_LAST, 321);
      step(1, ln_dum[i], i, ln_data[i]);
    end
  endtask

  task automatic check_stats(string tag);
    check(even_min == e_min[0], "R7", {tag, " even_min"}, even_min, e_min[0]);
    check(even_max == e_max[0], "R7", {tag, " even_max"}, even_max, e_max[0]);
    check(odd_min == e_min[1], "R7", {tag, " odd_min"}, odd_min, e_min[1]);
    check(odd_max == e_max[1], "R7", {tag, " odd_max"}, odd_max, e_max[1]);
    check(even_mean == e_mean[0], "R8", {tag, " even_mean"}, even_mean, e_mean[0]);
    check(odd_mean == e_mean[1], "R8", {tag, " odd_mean"}, odd_mean, e_mean[1]);
  endtask

  task automatic flush();
    repeat (3) step(0, 0, 0, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 0, "R11", "out_valid", out_valid, 0);
    check(line_done == 0, "R11", "line_done", line_done, 0);
    check({even_min, even_max, even_mean, odd_min, odd_max, odd_mean} == '0, "R11", "stats", even_min, 0);
  endtask

  task automatic t_ramp();
    for (int i = 0; i < LINE_LEN; i++) begin
      ln_dum[i] = 0;
      if (i >= BLK_FIRST && i <= BLK_LAST) ln_data[i] = (i % 2) ? 300 + i % 3 : 100 + i % 4;
      else ln_data[i] = (i * 37 + 11) % 4096;
    end
    run_line(0);
    flush();
    check_stats("ramp");
  endtask

  task automatic t_clamp();
    for (int i = 0; i < LINE_LEN; i++) begin
      ln_dum[i] = 0;
      if (i >= BLK_FIRST && i <= BLK_LAST) ln_data[i] = (i % 2) ? 3000 : 2000;
      else ln_data[i] = 500 + i % 1000;
    end
    run_line(0);
    flush();
    check_stats("clamp R4");
  endtask

  task automatic t_dummy_gaps();
    for (int i = 0; i < LINE_LEN; i++) begin
      ln_data[i] = rnd();
      ln_dum[i] = (i % 11 == 0);
      if (i >= BLK_FIRST && i <= BLK_LAST) ln_data[i] = ln_data[i] % 512;
    end
    run_line(1);
    flush();
    check_stats("dummy R6");
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < LINE_LEN; i++) begin
      ln_dum[i] = 0;
      ln_data[i] = (i >= BLK_FIRST && i <= BLK_LAST) ? ((i % 2) ? 60 : 50) : 1000 + rnd() % 2000;
    end
    ln_data[EFF_FIRST] = 4095;
    ln_data[EFF_LAST] = 0;
    run_line(0);
    check_stats("line A R10");
    for (int i = 0; i < LINE_LEN; i++) begin
      ln_data[i] = (i >= BLK_FIRST && i <= BLK_LAST) ? ((i % 2) ? 10 : 900) : 1000 + rnd() % 2000;
    end
    ln_data[EFF_FIRST] = 0;
    ln_data[EFF_LAST] = 4095;
    run_line(0);
    flush();
    check_stats("line B R10");
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ramp();
    t_clamp();
    t_dummy_gaps();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule